// File: doc/BRIEF.md
# Up-Counting Timer with Buffered Reload and Prescaler

This block is a general-purpose timer. Its counter climbs from zero to a programmable
limit, returns to zero, and marks each wrap with a one-cycle update event. Before each
counter step a clock divider waits a programmable number of extra timer clocks. Both the
limit and the divider setting are written into holding registers. They are copied into
the working registers only when an update event happens. This lets software retune the
period without tearing the cycle already in progress.

Software uses a small register port: a write strobe with address and data, and a
combinational read mux. A single enable input starts and stops the counting. Software can
force an update by writing a generate bit. It can block update events with a disable bit.
A sticky flag records that an update happened until software clears it.

Register map (3-bit address): 0 = control (bit 0 update-disable, bit 1 direction),
1 = divider holding value, 2 = limit holding value, 3 = event-generate (write-only, reads 0),
4 = status (bit 0 update flag), 5 = counter value (read-only).

Top module: `upTimer`

## Requirements
- R1: After reset the counter, update event, update flag, control bits, both holding registers and both working registers are 0.
- R2: While running with working divider value P, the counter advances by one on every (P+1)-th timer clock, counted from the point where counting started or the divider was last cleared.
- R3: When the counter equals the working limit and a step is due, it goes to 0 on that step. `updateEvent` is high for exactly the cycle in which the counter first reads 0 after the wrap.
- R4: A write to address 1 or 2 is visible at once when read back at that address. It changes the working divider or limit only at the next update event.
- R5: Writing address 3 with data bit 0 = 1 clears the counter and the divider's internal count to 0 on that clock edge. An update event follows unless update-disable is set. Address 3 always reads back 0.
- R6: While control bit 0 (update-disable) is 1, no update event occurs, the flag is not set and the working registers keep their values. The counter still wraps at the working limit.
- R7: The update flag goes to 1 on every update event. It stays 1 until software writes address 4 with data bit 0 = 0. If a set and a clear fall in the same cycle, the set wins.
- R8: While `cntEnable` is 0, the counter and the divider hold their values. Counting resumes from the held values when it returns to 1.
- R9: The counter counts only while control bit 1 (direction) is 0. With bit 1 = 1 it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntEnable | input | 1 | Counter enable |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | DATA_W | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | DATA_W | Register read data (combinational) |
| count | output | CNT_W | Current counter value |
| updateEvent | output | 1 | One-cycle update event pulse |
| updateFlag | output | 1 | Sticky update flag |

## Verification
The bench builds the timer with a 4-bit counter and a 2-bit divider. The sweep therefore covers every divider value, 0 to 3, against every limit, 0 to 15. That includes the limit of 0, where the counter wraps on every step, and the all-ones limit, where the counter wraps at its own maximum. In each pairing the expected counter value and event timing are computed from the step count. Directed runs then cover retuning while the timer runs, suppressed updates, forced updates in the middle of a divider period, and holding on enable and direction.

// File: rtl/upTimerPkg.sv
package upTimerPkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PSC    = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_EVENT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic run;        // counting permitted this cycle
    logic clearCnt;   // forced update request: zero counter and divider
    logic loadShadow; // update event: copy holding values to working regs
  } ctrlStrobes_t;
endpackage

// File: rtl/upTimerDatapath.sv
module upTimerDatapath
  import upTimerPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [PSC_W-1:0] pscHold,
  input  logic [CNT_W-1:0] reloadHold,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] activeReload,
  output logic             wrapNext
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PSC_W-1:0] PSC_ONE = PSC_W'(1);

  logic [PSC_W-1:0] activePsc;
  logic [PSC_W-1:0] divCnt;
  logic             stepDue;

  assign stepDue  = strobes.run && (divCnt == activePsc);
  assign wrapNext = stepDue && (count == activeReload);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      count  <= '0;
    end else if (strobes.clearCnt) begin
      divCnt <= '0;
      count  <= '0;
    end else if (strobes.run) begin
      if (stepDue) begin
        divCnt <= '0;
        count  <= (count == activeReload) ? '0 : count + CNT_ONE;
      end else begin
        divCnt <= divCnt + PSC_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activePsc    <= '0;
      activeReload <= '0;
    end else if (strobes.loadShadow) begin
      activePsc    <= pscHold;
      activeReload <= reloadHold;
    end
  end
endmodule

// File: rtl/upTimerControl.sv
module upTimerControl
  import upTimerPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntEnable,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [CNT_W-1:0]  count,
  input  logic              wrapNext,
  output ctrlStrobes_t      strobes,
  output logic [PSC_W-1:0]  pscHold,
  output logic [CNT_W-1:0]  reloadHold,
  output logic              updDisable,
  output logic              updateEvent,
  output logic              updateFlag
);
  logic dirDown;
  logic forceReq;
  logic flagClear;

  assign forceReq  = wrEn && (wrAddr == ADDR_EVENT) && wrData[0];
  assign flagClear = wrEn && (wrAddr == ADDR_STATUS) && !wrData[0];

  always_comb begin
    strobes.run        = cntEnable && !dirDown;
    strobes.clearCnt   = forceReq;
    strobes.loadShadow = (wrapNext || forceReq) && !updDisable;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updDisable <= 1'b0;
      dirDown    <= 1'b0;
      pscHold    <= '0;
      reloadHold <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTRL: begin
          updDisable <= wrData[0];
          dirDown    <= wrData[1];
        end
        ADDR_PSC:    pscHold    <= wrData[PSC_W-1:0];
        ADDR_RELOAD: reloadHold <= wrData[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updateEvent <= 1'b0;
      updateFlag  <= 1'b0;
    end else begin
      updateEvent <= strobes.loadShadow;
      if (strobes.loadShadow)  updateFlag <= 1'b1;
      else if (flagClear)      updateFlag <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_CTRL:   rdData = DATA_W'({dirDown, updDisable});
      ADDR_PSC:    rdData = DATA_W'(pscHold);
      ADDR_RELOAD: rdData = DATA_W'(reloadHold);
      ADDR_STATUS: rdData = DATA_W'(updateFlag);
      ADDR_COUNT:  rdData = DATA_W'(count);
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/upTimer.sv
module upTimer
  import upTimerPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntEnable,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count,
  output logic              updateEvent,
  output logic              updateFlag
);
  ctrlStrobes_t     strobes;
  logic [PSC_W-1:0] pscHold;
  logic [CNT_W-1:0] reloadHold;
  logic [CNT_W-1:0] activeReload;
  logic             wrapNext;
  logic             updDisable;

  upTimerControl #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntEnable(cntEnable),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .count(count), .wrapNext(wrapNext), .strobes(strobes),
    .pscHold(pscHold), .reloadHold(reloadHold), .updDisable(updDisable),
    .updateEvent(updateEvent), .updateFlag(updateFlag)
  );

  upTimerDatapath #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pscHold(pscHold), .reloadHold(reloadHold),
    .count(count), .activeReload(activeReload), .wrapNext(wrapNext)
  );
endmodule

// File: rtl/upTimerChecker.sv
module upTimerChecker #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cntEnable,
  input logic              wrEn,
  input logic [2:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  activeReload,
  input logic              updDisable,
  input logic              updateEvent,
  input logic              updateFlag
);
  // R3: event only when counter reads zero
  assert_event_at_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    updateEvent |-> (count == '0));

  // R3: counter never passes working limit
  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= activeReload);

  // R6: disabled updates yield no event
  assert_no_event_when_disabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(updDisable) |-> !updateEvent);

  // R7: flag follows every event
  assert_flag_on_event_R7: assert property (@(posedge clk) disable iff (!rstN)
    updateEvent |-> updateFlag);

  // R7: flag drops only by a clearing write
  assert_flag_clear_by_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(updateFlag) |-> $past(wrEn && wrAddr == 3'd4 && !wrData[0]));

  // R8: counter holds while disabled and no forced update
  assert_hold_when_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!cntEnable) && !$past(wrEn && wrAddr == 3'd3 && wrData[0])) |-> $stable(count));
endmodule

bind upTimer upTimerChecker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .cntEnable(cntEnable),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .count(count), .activeReload(activeReload), .updDisable(updDisable),
  .updateEvent(updateEvent), .updateFlag(updateFlag)
);

// File: tb/upTimer_bench.sv
module upTimer_bench;
  localparam int CNT_W  = 4;
  localparam int PSC_W  = 2;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cntEnable = 1'b0;
  logic              wrEn = 1'b0;
  logic [2:0]        wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [2:0]        rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic [CNT_W-1:0]  count;
  logic              updateEvent;
  logic              updateFlag;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  upTimer #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_upTimer (
    .clk(clk), .rstN(rstN), .cntEnable(cntEnable),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .count(count),
    .updateEvent(updateEvent), .updateFlag(updateFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input int addr, input int data);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = DATA_W'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input string req, input int addr, input int exp);
    rdAddr = 3'(addr);
    #1;
    check(req, int'(rdData), exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sweep(input int psc, input int rel);
    int per;
    int steps;
    per = psc + 1;
    cntEnable = 1'b0;
    writeReg(1, psc);
    writeReg(2, rel);
    writeReg(3, 1);
    check("R5 event on force", int'(updateEvent), 1);
    check("R5 count cleared", int'(count), 0);
    writeReg(4, 0);
    cntEnable = 1'b1;
    for (int t = 1; t <= 2 * per * (rel + 1) + 1; t++) begin
      @(negedge clk);
      steps = t / per;
      check("R2 count", int'(count), steps % (rel + 1));
      check("R3 event", int'(updateEvent),
            ((t % per == 0) && (steps % (rel + 1) == 0)) ? 1 : 0);
    end
    cntEnable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    check("R1 count", int'(count), 0);
    check("R1 event", int'(updateEvent), 0);
    check("R1 flag", int'(updateFlag), 0);
    readReg("R1 ctrl", 0, 0);
    readReg("R1 psc hold", 1, 0);
    readReg("R1 reload hold", 2, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2/R3 sweep over every divider and limit
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 16; r++)
        sweep(p, r);

    // R4: retune while running, takes effect after wrap
    writeReg(1, 0);
    writeReg(2, 5);
    writeReg(3, 1);
    writeReg(2, 2);
    readReg("R4 hold readback", 2, 2);
    cntEnable = 1'b1;
    idle(5);
    check("R4 old limit still used", int'(count), 5);
    @(negedge clk);
    check("R4 wrap at old limit", int'(count), 0);
    check("R4 event", int'(updateEvent), 1);
    idle(2);
    check("R4 new limit count", int'(count), 2);
    @(negedge clk);
    check("R4 wrap at new limit", int'(count), 0);
    cntEnable = 1'b0;
    readReg("R5 event reg reads 0", 3, 0);

    // R7 flag: clear by write 0, not by write 1
    check("R7 flag set", int'(updateFlag), 1);
    writeReg(4, 1);
    check("R7 flag kept on write 1", int'(updateFlag), 1);
    writeReg(4, 0);
    check("R7 flag cleared", int'(updateFlag), 0);

    // R6: disable suppresses event, flag and working load
    writeReg(0, 1);
    writeReg(2, 4);
    cntEnable = 1'b1;
    idle(2);
    check("R6 counter near old limit", int'(count), 2);
    @(negedge clk);
    check("R6 still wraps at old limit", int'(count), 0);
    check("R6 no event", int'(updateEvent), 0);
    check("R6 no flag", int'(updateFlag), 0);
    idle(3);
    check("R6 working limit unchanged", int'(count), 0);
    cntEnable = 1'b0;
    writeReg(3, 1);
    check("R6 forced clear but no event", int'(updateEvent), 0);
    check("R6 forced clear count", int'(count), 0);
    writeReg(0, 0);

    // R5: forced update mid-divider resets divider count
    writeReg(1, 3);
    writeReg(2, 9);
    writeReg(3, 1);
    writeReg(4, 0);
    cntEnable = 1'b1;
    idle(6);
    check("R5 pre-force count", int'(count), 1);
    writeReg(3, 1);
    check("R5 mid-run clear", int'(count), 0);
    check("R5 mid-run event", int'(updateEvent), 1);
    idle(3);
    check("R5 divider restarted", int'(count), 0);
    @(negedge clk);
    check("R5 first step after force", int'(count), 1);

    // R8: enable hold and resume
    cntEnable = 1'b0;
    idle(7);
    check("R8 hold", int'(count), 1);
    cntEnable = 1'b1;
    idle(4);
    check("R8 resume", int'(count), 2);

    // R9: direction bit 1 stops counting
    writeReg(0, 2);
    idle(8);
    check("R9 hold with dir 1", int'(count), 2);
    readReg("R9 ctrl readback", 0, 2);
    writeReg(0, 0);
    idle(4);
    check("R9 counts with dir 0", int'(count), 3);
    readReg("R9 count readback", 5, 3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule